// File: doc/BRIEF.md
# Panel Command Bus Master

This block lets software talk to an external display panel over a parallel bus of the kind used by simple microcontroller-style panels. Software stages a 32-bit word whose upper bits give the kind of access and whose low 18 bits carry the payload. A separate trigger write then starts the transfer on one of two panel channels. During the transfer the block holds a chip-select, a register-select line and the data bus, and it drives a write or read strobe for a pulse length chosen per launch.

Reads work the same way. Software marks the read word, triggers the read, polls the busy flag, and then collects the sampled panel data from the read register. The busy flag is set for the whole transfer. A launch that arrives while a transfer is running has no effect.

Register map (`regAddr`): 0 write word, 1 write trigger, 2 read word (written to prepare, read to collect), 3 read trigger, 4 status.

Top module: `panel_cmd_bus`

## Requirements
- R1: After reset the status busy bit (status bit 1) is 0, both chip-selects and both strobes are low, and the read register reads 0.
- R2: A write word with bit 28 set and bit 24 clear produces an index write. `panelRs` is 0 for the whole transfer, `panelDout` carries word bits 17:0 and `panelDoe` is 1.
- R3: A write word with bits 28 and 24 both set produces a data write. `panelRs` is 1 for the whole transfer.
- R4: Trigger bit 1 picks the channel: 1 drives `panelCs[1]`, 0 drives `panelCs[0]`. At most one chip-select is ever high. It stays high from the setup cycle through the hold cycle.
- R5: Trigger bits 11:8 give the strobe length N in clocks, and 0 counts as 1. A transfer has one setup cycle, then exactly N strobe cycles, then one hold cycle. Status bit 1 reads 1 for exactly those N+2 cycles, starting in the cycle after the trigger write.
- R6: A read is prepared by writing the read word with bit 24 set and started through the read trigger. `panelRd` pulses, `panelRs` is 1 and `panelDoe` is 0. `panelDin` is sampled in the last strobe cycle. The read register then returns it in bits 17:0 with bits 31:18 zero.
- R7: A trigger write while busy is ignored. The running transfer keeps its channel and length, and no second transfer follows.
- R8: A trigger with bit 0 clear starts nothing. A write trigger starts nothing when the staged write word has bit 28 clear. A read trigger starts nothing when the read word was written with bit 24 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on `regAddr`) |
| panelCs | output | 2 | Per-channel chip-select, active high (0 main, 1 sub) |
| panelRs | output | 1 | Register select: 0 index, 1 data |
| panelWr | output | 1 | Write strobe, active high |
| panelRd | output | 1 | Read strobe, active high |
| panelDout | output | 18 | Data driven to the panel |
| panelDoe | output | 1 | Output enable for `panelDout` |
| panelDin | input | 18 | Data returned by the panel |

## Verification
The embedded properties check on every cycle that at most one chip-select is high, that a strobe never appears without a chip-select, and that the bus is not driven during a read. They also check that `panelRs` holds steady through a transfer, that a strobe always follows a setup cycle, and that a trigger during a transfer never restarts it. The bench scenarios are needed for the rest. Only they show that exactly N strobe cycles and N+2 busy cycles occur for each length, including 0 and 15. They also show which channel and payload reach the pins, that the read sample is taken inside the strobe and masked to 18 bits, and that malformed or unarmed launches leave the bus idle.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int ADDR_W   = 3;
  localparam int REG_W    = 32;
  localparam int TYPE_BIT = 28;
  localparam int RS_BIT   = 24;
  localparam int GO_BIT   = 0;
  localparam int CH_BIT   = 1;
  localparam int LEN_LSB  = 8;
  localparam int BUSY_BIT = 1;

  localparam logic [ADDR_W-1:0] A_WWORD = 3'd0;
  localparam logic [ADDR_W-1:0] A_WTRIG = 3'd1;
  localparam logic [ADDR_W-1:0] A_RWORD = 3'd2;
  localparam logic [ADDR_W-1:0] A_RTRIG = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_t;

  typedef struct packed {
    logic launchWr;
    logic launchRd;
    logic active;
    logic strobe;
    logic hold;
    logic capture;
  } seq_ctl_t;
endpackage

// File: rtl/pcb_seq.sv
module pcb_seq
  import pcb_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              trigGo,
  input  logic [LEN_W-1:0]  trigLen,
  input  logic              wordIsCmd,
  input  logic              prepIsRead,
  output seq_ctl_t          ctl
);
  phase_t            phase;
  logic [LEN_W-1:0]  remain;
  logic              isRd;
  logic              idle;
  logic              wrReq;
  logic              rdReq;
  logic [LEN_W-1:0]  lenEff;

  assign idle   = (phase == PH_IDLE);
  assign wrReq  = regWe && (regAddr == A_WTRIG) && trigGo && wordIsCmd;
  assign rdReq  = regWe && (regAddr == A_RTRIG) && trigGo && prepIsRead;
  assign lenEff = (trigLen == '0) ? LEN_W'(1) : trigLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      remain <= '0;
      isRd   <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (wrReq || rdReq) begin
          phase  <= PH_SETUP;
          remain <= lenEff - LEN_W'(1);
          isRd   <= rdReq;
        end
        PH_SETUP:  phase <= PH_STROBE;
        PH_STROBE: if (remain == '0) phase <= PH_HOLD;
                   else remain <= remain - LEN_W'(1);
        PH_HOLD:   phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.launchWr = idle && wrReq;
    ctl.launchRd = idle && rdReq && !wrReq;
    ctl.active   = !idle;
    ctl.strobe   = (phase == PH_STROBE);
    ctl.hold     = (phase == PH_HOLD);
    ctl.capture  = (phase == PH_STROBE) && (remain == '0) && isRd;
  end

  // R7: a trigger during a transfer never restarts the sequence
  a_r7_no_relaunch: assert property (@(posedge clk) disable iff (!rstN)
    (!idle && regWe && (regAddr == A_WTRIG || regAddr == A_RTRIG)) |=> (phase != PH_SETUP));

  // R5: the strobe phase is always entered from the setup phase
  a_r5_setup_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phase == PH_STROBE) |-> ($past(phase) == PH_SETUP));

  // R5: the last strobe cycle is followed by the hold cycle
  a_r5_hold_after: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE && remain == '0) |=> (phase == PH_HOLD));
endmodule

// File: rtl/pcb_datapath.sv
module pcb_datapath
  import pcb_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  seq_ctl_t          ctl,
  output logic              wordIsCmd,
  output logic              prepIsRead,
  output logic [NUM_CH-1:0] panelCs,
  output logic              panelRs,
  output logic              panelWr,
  output logic              panelRd,
  output logic [DATA_W-1:0] panelDout,
  output logic              panelDoe,
  input  logic [DATA_W-1:0] panelDin
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [REG_W-1:0]  wordQ;
  logic              prepQ;
  logic [DATA_W-1:0] rdDataQ;
  logic [DATA_W-1:0] outQ;
  logic [CH_W-1:0]   chQ;
  logic              rsQ;
  logic              dirRdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ   <= '0;
      prepQ   <= 1'b0;
      rdDataQ <= '0;
      outQ    <= '0;
      chQ     <= '0;
      rsQ     <= 1'b0;
      dirRdQ  <= 1'b0;
    end else begin
      if (regWe && regAddr == A_WWORD) wordQ <= regWdata;
      if (regWe && regAddr == A_RWORD) prepQ <= regWdata[RS_BIT];
      if (ctl.launchWr) begin
        chQ    <= CH_W'(regWdata[CH_BIT]);
        rsQ    <= wordQ[RS_BIT];
        outQ   <= wordQ[DATA_W-1:0];
        dirRdQ <= 1'b0;
      end else if (ctl.launchRd) begin
        chQ    <= CH_W'(regWdata[CH_BIT]);
        rsQ    <= prepQ;
        dirRdQ <= 1'b1;
      end
      if (ctl.capture) rdDataQ <= panelDin;
    end
  end

  assign wordIsCmd  = wordQ[TYPE_BIT];
  assign prepIsRead = prepQ;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cs
    assign panelCs[c] = ctl.active && (chQ == CH_W'(c));
  end

  assign panelRs   = rsQ;
  assign panelWr   = ctl.strobe && !dirRdQ;
  assign panelRd   = ctl.strobe && dirRdQ;
  assign panelDout = outQ;
  assign panelDoe  = ctl.active && !dirRdQ;

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      A_WWORD: regRdata = wordQ;
      A_RWORD: regRdata = REG_W'(rdDataQ);
      A_STAT:  regRdata[BUSY_BIT] = ctl.active;
      default: regRdata = '0;
    endcase
  end

  // R4: never more than one chip-select
  a_r4_one_cs: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(panelCs));

  // R4: a strobe only occurs under a chip-select
  a_r4_cs_with_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (panelWr || panelRd) |-> (panelCs != '0));

  // R2: register select holds through a transfer
  a_r2_rs_stable: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && !ctl.hold) |=> $stable(panelRs));

  // R6: the bus is released while reading
  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    panelRd |-> !panelDoe);
endmodule

// File: rtl/panel_cmd_bus.sv
module panel_cmd_bus
  import pcb_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int LEN_W  = 4,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic [NUM_CH-1:0] panelCs,
  output logic              panelRs,
  output logic              panelWr,
  output logic              panelRd,
  output logic [DATA_W-1:0] panelDout,
  output logic              panelDoe,
  input  logic [DATA_W-1:0] panelDin
);
  seq_ctl_t ctl;
  logic     wordIsCmd;
  logic     prepIsRead;

  pcb_seq #(.LEN_W(LEN_W)) uSeq (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .trigGo     (regWdata[GO_BIT]),
    .trigLen    (regWdata[LEN_LSB +: LEN_W]),
    .wordIsCmd  (wordIsCmd),
    .prepIsRead (prepIsRead),
    .ctl        (ctl)
  );

  pcb_datapath #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .ctl        (ctl),
    .wordIsCmd  (wordIsCmd),
    .prepIsRead (prepIsRead),
    .panelCs    (panelCs),
    .panelRs    (panelRs),
    .panelWr    (panelWr),
    .panelRd    (panelRd),
    .panelDout  (panelDout),
    .panelDoe   (panelDoe),
    .panelDin   (panelDin)
  );
endmodule

// File: tb/tb_panel_cmd_bus.sv
`timescale 1ns/1ps
module tb_panel_cmd_bus;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = 3'd4;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [1:0]  panelCs;
  logic        panelRs, panelWr, panelRd, panelDoe;
  logic [17:0] panelDout, panelDin;
  logic [17:0] rspVal = '0;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  assign panelDin = panelRd ? rspVal : 18'h0;

  panel_cmd_bus dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .panelCs(panelCs),
    .panelRs(panelRs), .panelWr(panelWr), .panelRd(panelRd),
    .panelDout(panelDout), .panelDoe(panelDoe), .panelDin(panelDin)
  );

  typedef struct packed {
    logic        isRd;
    logic        ch;
    logic [3:0]  len;
    logic [31:0] word;
    logic [17:0] rdv;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 4'd1,  32'h1000_0036, 18'h0},
    '{1'b0, 1'b1, 4'd3,  32'h1100_2ABC, 18'h0},
    '{1'b0, 1'b0, 4'd0,  32'h1103_FFFF, 18'h0},
    '{1'b1, 1'b1, 4'd2,  32'hF1FF_0000, 18'h2_5A5A},
    '{1'b1, 1'b0, 4'd15, 32'h0100_0000, 18'h1_2345},
    '{1'b0, 1'b1, 4'd15, 32'h1000_0155, 18'h0}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regAddr = 3'd4;
  endtask

  task automatic runXfer(input vec_t v, input bit intrude, input string tag);
    logic [31:0] trig;
    int n, csCnt, stbCnt, firstStb, csBad, rsBad, busyBad, datBad;
    logic [1:0] expCs;
    logic expRs;
    n = (v.len == 0) ? 1 : int'(v.len);
    trig = (32'(v.len) << 8) | (32'(v.ch) << 1) | 32'h1;
    expCs = v.ch ? 2'b10 : 2'b01;
    expRs = v.isRd ? 1'b1 : v.word[24];
    csCnt = 0; stbCnt = 0; firstStb = -1; csBad = 0; rsBad = 0; busyBad = 0; datBad = 0;
    if (v.isRd) begin
      rspVal = v.rdv;
      regWrite(3'd2, v.word);
      regWrite(3'd3, trig);
    end else begin
      regWrite(3'd0, v.word);
      regWrite(3'd1, trig);
    end
    for (int c = 0; c < 40; c++) begin
      if (intrude && c == 3) begin
        regWe = 1'b1; regAddr = 3'd1; regWdata = trig ^ 32'h0000_0F02;
      end else begin
        regWe = 1'b0; regAddr = 3'd4;
      end
      #1;
      if (panelCs != 2'b00) begin
        csCnt++;
        if (panelCs != expCs) csBad++;
        if (panelRs != expRs) rsBad++;
        if (!(intrude && c == 3) && regRdata[1] != 1'b1) busyBad++;
        if (!v.isRd && (panelDout != v.word[17:0] || !panelDoe)) datBad++;
        if (v.isRd && panelDoe) datBad++;
      end else if (regAddr == 3'd4 && regRdata[1] != 1'b0) busyBad++;
      if (panelWr || panelRd) begin
        stbCnt++;
        if (firstStb < 0) firstStb = c;
        if (panelRd != v.isRd) datBad++;
      end
      @(negedge clk);
    end
    regWe = 1'b0; regAddr = 3'd4;
    check(intrude ? "R7" : "R5", {tag, " busy/cs cycles"}, csCnt, n + 2);
    check("R5", {tag, " strobe cycles"}, stbCnt, n);
    check("R5", {tag, " first strobe after setup"}, firstStb, 1);
    check(intrude ? "R7" : "R4", {tag, " chip-select"}, csBad, 0);
    check(v.isRd ? "R6" : (v.word[24] ? "R3" : "R2"), {tag, " rs"}, rsBad, 0);
    check("R5", {tag, " status busy"}, busyBad, 0);
    check(v.isRd ? "R6" : "R2", {tag, " data/direction"}, datBad, 0);
    if (v.isRd) begin
      regAddr = 3'd2; #1;
      check("R6", {tag, " read data masked"}, int'(regRdata), int'({14'b0, v.rdv}));
      regAddr = 3'd4;
    end
  endtask

  task automatic expectIdle(input string tag);
    int act;
    act = 0;
    for (int c = 0; c < 6; c++) begin
      #1;
      if (panelCs != 0 || panelWr || panelRd || regRdata[1]) act++;
      @(negedge clk);
    end
    check("R8", tag, act, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", "reset busy", int'(regRdata[1]), 0);
    check("R1", "reset cs", int'(panelCs), 0);
    check("R1", "reset strobes", int'({panelWr, panelRd}), 0);
    regAddr = 3'd2; #1;
    check("R1", "reset read reg", int'(regRdata), 0);
    regAddr = 3'd4;
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) runXfer(VECS[i], 1'b0, $sformatf("vec%0d", i));

    // R7: relaunch attempt in the middle of a long transfer
    runXfer('{1'b0, 1'b0, 4'd15, 32'h1100_0077, 18'h0}, 1'b1, "intrude");

    // R8: staged word without bit 28
    regWrite(3'd0, 32'h0100_1234);
    regWrite(3'd1, 32'h0000_0301);
    expectIdle("write word lacks type bit");
    // R8: trigger without go bit
    regWrite(3'd0, 32'h1100_1234);
    regWrite(3'd1, 32'h0000_0302);
    expectIdle("write trigger go clear");
    // R8: read word without bit 24
    regWrite(3'd2, 32'hFE00_0000);
    regWrite(3'd3, 32'h0000_0201);
    expectIdle("read word lacks bit 24");
    // R8: read trigger without go bit
    regWrite(3'd2, 32'h0100_0000);
    regWrite(3'd3, 32'h0000_0200);
    expectIdle("read trigger go clear");

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule